// File: doc/BRIEF.md
# Multiprocessor-Filtering Serial Interface

This block is an asynchronous serial transmitter and receiver that a CPU reaches through four byte-wide registers: control, status, transmit data and receive data. Each frame is one start bit, eight data bits sent least significant bit first, one address/data marker bit and one stop bit. Each bit lasts sixteen pulses of an external oversampling tick. Four level interrupt lines report transmit-empty, transmit-end, receive-full and receive-error. Each line is the matching status flag gated by an enable bit in the control register.

The marker bit supports multidrop links. Software arms a wait bit. While the wait bit is set, the receiver drops every frame whose marker is 0, with no flag or interrupt activity. The first frame whose marker is 1 is delivered as an address and disarms the wait bit on its own. Software then reads the address and decides whether to listen to the data frames that follow. Status flags are cleared only by a read that returned 1 followed by a write of 0, so a flag raised between the read and the write is never lost.

Top module: `mp_uart`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the status register (address 1) reads 0x03, txd is 1 and all four interrupt outputs are 0.
- R2: While transmit enable (control bit 0) is 0, the transmit-empty flag (status bit 0) reads 1, and a write of 0 to it has no effect.
- R3: A status flag is cleared by writing 0 to its bit only after a status read that returned 1 for that bit. A write of 0 with no such earlier read leaves the flag unchanged, and a write of 1 never changes a flag.
- R4: Once transmit is enabled, txd stays high until the transmit data register (address 2) is written and transmit-empty is cleared. The frame is then sent as a start bit of 0, the eight data bits least significant first, the marker from control bit 3, and a stop bit of 1, each bit lasting 16 ticks. Transmit-empty returns to 1 when the byte is taken.
- R5: Transmit-end (status bit 1) is cleared when a frame starts. It is set when a frame finishes with no byte pending. It is removed by the read-then-clear rule.
- R6: With receive enable (control bit 1) set, a falling edge on rxd starts reception and every bit is sampled at mid-bit. A low pulse that is high again at mid-bit of the start bit is ignored.
- R7: An accepted frame stores its byte in the receive data register (address 3), sets receive-full (status bit 2), copies its marker into status bit 5, and sets framing error (status bit 3) if its stop bit was 0.
- R8: A frame accepted while receive-full is still 1 sets overrun (status bit 4) and leaves the receive data register unchanged.
- R9: While the wait bit (control bit 2) is 1, a frame with marker 0 changes neither receive data nor status bits 2 to 5, even if its stop bit is 0.
- R10: While waiting, a frame with marker 1 clears the wait bit, sets status bit 5 and is delivered as in R7.
- R11: Clearing receive enable leaves receive-full, framing error and overrun unchanged, and frames sent while it is 0 are not received.
- R12: Each interrupt output is its flag gated by its enable: transmit-empty by control bit 4, transmit-end by bit 5, receive-full by bit 6, and receive-error (framing or overrun) by bit 7. Clearing the enable removes the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe; marks the access that arms flag clearing |
| busAddr | input | 2 | 0 control, 1 status, 2 transmit data, 3 receive data |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input |
| irqTxEmpty | output | 1 | Transmit-empty interrupt |
| irqTxEnd | output | 1 | Transmit-end interrupt |
| irqRxFull | output | 1 | Receive-full interrupt |
| irqRxErr | output | 1 | Framing or overrun interrupt |

## Verification
Receive frames are driven with marker 0 and 1 and with a good or bad stop bit. They arrive with the wait bit off and on, with receive-full already set, and with the receiver disabled. These cases separate delivery, overrun, discard, address wake-up and disabled reception. A short low glitch shows the start-bit check at mid-bit. A transmit byte of alternating pattern with marker 1 shows bit order and the start, marker and stop positions. Writes of 0 before and after a status read show the read-then-clear rule.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
  localparam int DATA_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_TXD  = 2'd2;
  localparam logic [1:0] ADDR_RXD  = 2'd3;

  // control bits
  localparam int C_TXEN   = 0;
  localparam int C_RXEN   = 1;
  localparam int C_WAIT   = 2;
  localparam int C_TXMPB  = 3;
  localparam int C_IETXE  = 4;
  localparam int C_IETXD  = 5;
  localparam int C_IERXF  = 6;
  localparam int C_IERXE  = 7;

  // status bits
  localparam int S_TXEMPTY = 0;
  localparam int S_TXEND   = 1;
  localparam int S_RXFULL  = 2;
  localparam int S_FERR    = 3;
  localparam int S_OERR    = 4;
  localparam int S_RXMPB   = 5;

  typedef struct packed {
    logic              txLoad;
    logic [DATA_W-1:0] txByte;
    logic              txMpb;
    logic              rxEnable;
  } ctrlStrobe_t;

  typedef struct packed {
    logic              txBusy;
    logic              txDone;
    logic              rxDone;
    logic [DATA_W-1:0] rxByte;
    logic              rxMpb;
    logic              rxStopOk;
  } dpEvent_t;
endpackage

// File: rtl/mp_uart_dp.sv
module mp_uart_dp
  import mp_uart_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        rxd,
  input  ctrlStrobe_t cs,
  output dpEvent_t    ev,
  output logic        txd
);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int SAMP_W     = DATA_W + 2;
  localparam int TICK_W     = $clog2(OVERSAMPLE);
  localparam int BIT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVERSAMPLE - 1);
  localparam logic [TICK_W-1:0] TICK_MID  = TICK_W'(OVERSAMPLE / 2 - 1);
  localparam logic [BIT_W-1:0]  IDX_LAST  = BIT_W'(FRAME_BITS - 1);

  // transmitter
  logic [FRAME_BITS-1:0] txSh;
  logic [TICK_W-1:0]     txTick;
  logic [BIT_W-1:0]      txIdx;
  logic                  txBusy, txDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh   <= '1;
      txTick <= '0;
      txIdx  <= '0;
      txBusy <= 1'b0;
      txDone <= 1'b0;
    end else begin
      txDone <= 1'b0;
      if (cs.txLoad && !txBusy) begin
        txSh   <= {1'b1, cs.txMpb, cs.txByte, 1'b0};
        txTick <= '0;
        txIdx  <= '0;
        txBusy <= 1'b1;
      end else if (txBusy && tick) begin
        if (txTick == TICK_LAST) begin
          txTick <= '0;
          txSh   <= {1'b1, txSh[FRAME_BITS-1:1]};
          if (txIdx == IDX_LAST) begin
            txBusy <= 1'b0;
            txDone <= 1'b1;
          end else begin
            txIdx <= txIdx + 1'b1;
          end
        end else begin
          txTick <= txTick + 1'b1;
        end
      end
    end
  end

  assign txd = txBusy ? txSh[0] : 1'b1;

  // receiver
  logic              rxMeta, rxSync, rxPrev;
  logic              rxBusy, rxDone, rxMpb, rxStopOk;
  logic [TICK_W-1:0] rxTick;
  logic [BIT_W-1:0]  rxIdx;
  logic [SAMP_W-1:0] rxSh, rxNext;
  logic [DATA_W-1:0] rxByte;

  assign rxNext = {rxSync, rxSh[SAMP_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta   <= 1'b1;
      rxSync   <= 1'b1;
      rxPrev   <= 1'b1;
      rxBusy   <= 1'b0;
      rxDone   <= 1'b0;
      rxTick   <= '0;
      rxIdx    <= '0;
      rxSh     <= '0;
      rxByte   <= '0;
      rxMpb    <= 1'b0;
      rxStopOk <= 1'b0;
    end else begin
      rxMeta <= rxd;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
      rxDone <= 1'b0;
      if (!cs.rxEnable) begin
        rxBusy <= 1'b0;
      end else if (!rxBusy) begin
        if (rxPrev && !rxSync) begin
          rxBusy <= 1'b1;
          rxTick <= '0;
          rxIdx  <= '0;
        end
      end else if (tick) begin
        if (rxTick == TICK_MID) begin
          if (rxIdx == '0) begin
            if (rxSync) rxBusy <= 1'b0;  // glitch, not a start bit
          end else begin
            rxSh <= rxNext;
            if (rxIdx == IDX_LAST) begin
              rxBusy   <= 1'b0;
              rxDone   <= 1'b1;
              rxByte   <= rxNext[DATA_W-1:0];
              rxMpb    <= rxNext[DATA_W];
              rxStopOk <= rxNext[DATA_W+1];
            end
          end
        end
        if (rxTick == TICK_LAST) begin
          rxTick <= '0;
          rxIdx  <= rxIdx + 1'b1;
        end else begin
          rxTick <= rxTick + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ev.txBusy   = txBusy;
    ev.txDone   = txDone;
    ev.rxDone   = rxDone;
    ev.rxByte   = rxByte;
    ev.rxMpb    = rxMpb;
    ev.rxStopOk = rxStopOk;
  end
endmodule

// File: rtl/mp_uart_ctrl.sv
module mp_uart_ctrl
  import mp_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  dpEvent_t          ev,
  output ctrlStrobe_t       cs,
  output logic [7:0]        ctrlReg,
  output logic [7:0]        statVec,
  output logic              irqTxEmpty,
  output logic              irqTxEnd,
  output logic              irqRxFull,
  output logic              irqRxErr
);
  logic [DATA_W-1:0] txBuf, rxBuf;
  logic [7:0] armed, clrOk;
  logic fTxEmpty, fTxEnd, fRxFull, fFerr, fOerr, rxMpbStat;
  logic wrCtrl, wrStat, wrTx, rdStat, accept;

  assign wrCtrl = busSel && busWr && (busAddr == ADDR_CTRL);
  assign wrStat = busSel && busWr && (busAddr == ADDR_STAT);
  assign wrTx   = busSel && busWr && (busAddr == ADDR_TXD);
  assign rdStat = busSel && busRd && (busAddr == ADDR_STAT);
  assign clrOk  = wrStat ? (armed & ~busWdata) : 8'h00;

  assign statVec = {2'b00, rxMpbStat, fOerr, fFerr, fRxFull, fTxEnd,
                    fTxEmpty | ~ctrlReg[C_TXEN]};

  assign accept = ev.rxDone && ctrlReg[C_RXEN] && (!ctrlReg[C_WAIT] || ev.rxMpb);

  always_comb begin
    cs.txLoad   = ctrlReg[C_TXEN] && !fTxEmpty && !ev.txBusy;
    cs.txByte   = txBuf;
    cs.txMpb    = ctrlReg[C_TXMPB];
    cs.rxEnable = ctrlReg[C_RXEN];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      txBuf     <= '0;
      rxBuf     <= '0;
      armed     <= '0;
      fTxEmpty  <= 1'b1;
      fTxEnd    <= 1'b1;
      fRxFull   <= 1'b0;
      fFerr     <= 1'b0;
      fOerr     <= 1'b0;
      rxMpbStat <= 1'b0;
    end else begin
      if (wrCtrl) ctrlReg <= busWdata;
      if (wrTx)   txBuf   <= busWdata;

      if (wrStat)      armed <= '0;
      else if (rdStat) armed <= armed | statVec;

      if (!ctrlReg[C_TXEN] || cs.txLoad) fTxEmpty <= 1'b1;
      else if (clrOk[S_TXEMPTY])        fTxEmpty <= 1'b0;

      if (cs.txLoad)                             fTxEnd <= 1'b0;
      else if (ev.txDone && statVec[S_TXEMPTY])  fTxEnd <= 1'b1;
      else if (clrOk[S_TXEND])                   fTxEnd <= 1'b0;

      if (clrOk[S_RXFULL]) fRxFull <= 1'b0;
      if (clrOk[S_FERR])   fFerr   <= 1'b0;
      if (clrOk[S_OERR])   fOerr   <= 1'b0;

      if (accept) begin
        rxMpbStat <= ev.rxMpb;
        if (ctrlReg[C_WAIT]) ctrlReg[C_WAIT] <= 1'b0;
        if (fRxFull) begin
          fOerr <= 1'b1;
        end else begin
          rxBuf   <= ev.rxByte;
          fRxFull <= 1'b1;
          if (!ev.rxStopOk) fFerr <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRdata = ctrlReg;
      ADDR_STAT: busRdata = statVec;
      ADDR_TXD:  busRdata = txBuf;
      default:   busRdata = rxBuf;
    endcase
  end

  assign irqTxEmpty = ctrlReg[C_IETXE] && statVec[S_TXEMPTY];
  assign irqTxEnd   = ctrlReg[C_IETXD] && fTxEnd;
  assign irqRxFull  = ctrlReg[C_IERXF] && fRxFull;
  assign irqRxErr   = ctrlReg[C_IERXE] && (fFerr || fOerr);
endmodule

// File: rtl/mp_uart.sv
module mp_uart
  import mp_uart_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       busSel,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       txd,
  input  logic       rxd,
  output logic       irqTxEmpty,
  output logic       irqTxEnd,
  output logic       irqRxFull,
  output logic       irqRxErr
);
  ctrlStrobe_t cs;
  dpEvent_t    ev;
  logic [7:0]  ctrlReg, statVec;

  mp_uart_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .ev(ev), .cs(cs), .ctrlReg(ctrlReg), .statVec(statVec),
    .irqTxEmpty(irqTxEmpty), .irqTxEnd(irqTxEnd),
    .irqRxFull(irqRxFull), .irqRxErr(irqRxErr)
  );

  mp_uart_dp #(.OVERSAMPLE(OVERSAMPLE)) i_dp (
    .clk(clk), .rstN(rstN), .tick(tick16), .rxd(rxd),
    .cs(cs), .ev(ev), .txd(txd)
  );
endmodule

// File: rtl/mp_uart_chk.sv
module mp_uart_chk
  import mp_uart_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic       busWr,
  input logic [1:0] busAddr,
  input logic [7:0] ctrlReg,
  input logic [7:0] statVec
);
  // R2
  tx_empty_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statVec[S_TXEMPTY]) |-> ctrlReg[C_TXEN] &&
      $past(busSel && busWr && busAddr == ADDR_STAT));

  // R3
  rx_full_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statVec[S_RXFULL]) |-> $past(busSel && busWr && busAddr == ADDR_STAT));

  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statVec[S_OERR]) |-> $past(statVec[S_RXFULL]));

  // R10
  wait_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statVec[S_RXFULL]) && $past(ctrlReg[C_WAIT])) |-> !ctrlReg[C_WAIT]);

  // R11
  rx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[C_RXEN] && $past(!ctrlReg[C_RXEN])) |-> !$rose(statVec[S_RXFULL]));
endmodule

bind mp_uart mp_uart_chk i_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .ctrlReg(ctrlReg), .statVec(statVec)
);

// File: tb/test_mp_uart.sv
module test_mp_uart;
  logic clk = 1'b0, rstN = 1'b0, tick16 = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic txd, rxd = 1'b1;
  logic irqTxEmpty, irqTxEnd, irqRxFull, irqRxErr;
  int checks = 0, errors = 0, tdiv = 0;

  mp_uart i_mp_uart (
    .clk(clk), .rstN(rstN), .tick16(tick16), .busSel(busSel), .busWr(busWr),
    .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .txd(txd), .rxd(rxd), .irqTxEmpty(irqTxEmpty), .irqTxEnd(irqTxEnd),
    .irqRxFull(irqRxFull), .irqRxErr(irqRxErr)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 3);
  end

  task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busRd = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0; busRd = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic mpb, input logic stp);
    logic [10:0] bits;
    bits = {stp, mpb, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = bits[i];
      repeat (64) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl", 11'(v), 11'h00);
    rd(2'd1, v); chk("R1 status", 11'(v), 11'h03);
    chk("R1 txd/irqs", {6'd0, txd, irqTxEmpty, irqTxEnd, irqRxFull, irqRxErr}, 11'b10000);
  endtask

  task automatic t_txEmptyFixed();
    logic [7:0] v;
    rd(2'd1, v);
    wr(2'd1, 8'hFE);
    rd(2'd1, v); chk("R2 empty fixed while disabled", 11'(v[0]), 11'd1);
    wr(2'd0, 8'h10);
    @(negedge clk); chk("R12 irqTxEmpty gated on", 11'(irqTxEmpty), 11'd1);
    wr(2'd0, 8'h00);
    @(negedge clk); chk("R12 irqTxEmpty enable cleared", 11'(irqTxEmpty), 11'd0);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    logic [10:0] cap;
    int waitCnt;
    wr(2'd2, 8'hA5);
    wr(2'd0, 8'h09);
    repeat (100) @(negedge clk);
    chk("R4 no start before clear", 11'(txd), 11'd1);
    rd(2'd1, v); chk("R4 status before clear", 11'(v), 11'h03);
    wr(2'd1, 8'hFE);
    waitCnt = 0;
    while (txd === 1'b1 && waitCnt < 40) begin
      @(negedge clk); waitCnt++;
    end
    repeat (32) @(negedge clk);
    cap[0] = txd;
    for (int i = 1; i < 11; i++) begin
      repeat (64) @(negedge clk);
      cap[i] = txd;
    end
    chk("R4 start bit", 11'(cap[0]), 11'd0);
    chk("R4 data LSB first", 11'(cap[8:1]), 11'hA5);
    chk("R4 marker bit", 11'(cap[9]), 11'd1);
    chk("R4 stop bit", 11'(cap[10]), 11'd1);
    repeat (40) @(negedge clk);
    rd(2'd1, v); chk("R5 end set, empty refilled", 11'(v[1:0]), 11'h3);
    wr(2'd0, 8'h29);
    @(negedge clk); chk("R12 irqTxEnd", 11'(irqTxEnd), 11'd1);
    rd(2'd1, v);
    wr(2'd1, 8'hFD);
    rd(2'd1, v); chk("R5 end cleared by read-then-clear", 11'(v[1]), 11'd0);
    chk("R5 irqTxEnd removed", 11'(irqTxEnd), 11'd0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_rxBasic();
    logic [7:0] v;
    wr(2'd0, 8'h02);
    sendFrame(8'h3C, 1'b0, 1'b1);
    rd(2'd1, v); chk("R7 rx status", 11'(v & 8'h3C), 11'h04);
    rd(2'd3, v); chk("R7 rx data", 11'(v), 11'h3C);
    wr(2'd1, 8'hFB);
    rd(2'd1, v); chk("R3 rx full cleared", 11'(v[2]), 11'd0);
    rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
    repeat (800) @(negedge clk);
    rd(2'd1, v); chk("R6 glitch ignored", 11'(v & 8'h3C), 11'h00);
    sendFrame(8'h81, 1'b1, 1'b0);
    rd(2'd1, v); chk("R7 framing error and marker", 11'(v & 8'h3C), 11'h2C);
    rd(2'd3, v); chk("R7 data with bad stop", 11'(v), 11'h81);
    wr(2'd0, 8'h82);
    @(negedge clk); chk("R12 irqRxErr", 11'(irqRxErr), 11'd1);
    wr(2'd0, 8'h02);
    @(negedge clk); chk("R12 irqRxErr enable cleared", 11'(irqRxErr), 11'd0);
  endtask

  task automatic t_clearRule();
    logic [7:0] v;
    wr(2'd1, 8'hFF);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R3 write 0 without read ignored", 11'(v & 8'h0C), 11'h0C);
    wr(2'd1, 8'hF3);
    rd(2'd1, v); chk("R3 read then write 0 clears", 11'(v & 8'h0C), 11'h00);
  endtask

  task automatic t_rxDisable();
    logic [7:0] v;
    sendFrame(8'h55, 1'b0, 1'b1);
    wr(2'd0, 8'h00);
    rd(2'd1, v); chk("R11 full kept after disable", 11'(v & 8'h1C), 11'h04);
    sendFrame(8'h66, 1'b0, 1'b1);
    rd(2'd3, v); chk("R11 no reception while disabled", 11'(v), 11'h55);
    rd(2'd1, v); chk("R11 no overrun while disabled", 11'(v[4]), 11'd0);
    wr(2'd0, 8'h02);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    sendFrame(8'h77, 1'b0, 1'b1);
    rd(2'd1, v); chk("R8 overrun set", 11'(v & 8'h1C), 11'h14);
    rd(2'd3, v); chk("R8 data kept", 11'(v), 11'h55);
    wr(2'd0, 8'h42);
    @(negedge clk); chk("R12 irqRxFull", 11'(irqRxFull), 11'd1);
    wr(2'd0, 8'h02);
    @(negedge clk); chk("R12 irqRxFull enable cleared", 11'(irqRxFull), 11'd0);
    rd(2'd1, v);
    wr(2'd1, 8'hEB);
    rd(2'd1, v); chk("R3 full and overrun cleared", 11'(v & 8'h1C), 11'h00);
  endtask

  task automatic t_mpWait();
    logic [7:0] v;
    wr(2'd0, 8'h06);
    sendFrame(8'h11, 1'b0, 1'b1);
    rd(2'd1, v); chk("R9 data frame dropped", 11'(v & 8'h1C), 11'h00);
    rd(2'd0, v); chk("R9 wait still armed", 11'(v), 11'h06);
    sendFrame(8'h12, 1'b0, 1'b0);
    rd(2'd1, v); chk("R9 no framing error while waiting", 11'(v & 8'h3C), 11'h00);
    sendFrame(8'h22, 1'b1, 1'b1);
    rd(2'd1, v); chk("R10 address frame status", 11'(v & 8'h3C), 11'h24);
    rd(2'd0, v); chk("R10 wait disarmed", 11'(v), 11'h02);
    rd(2'd3, v); chk("R10 address byte", 11'(v), 11'h22);
    rd(2'd1, v);
    wr(2'd1, 8'hFB);
    sendFrame(8'h33, 1'b0, 1'b1);
    rd(2'd3, v); chk("R10 data after wake", 11'(v), 11'h33);
    rd(2'd1, v); chk("R7 marker copied as 0", 11'(v & 8'h3C), 11'h04);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_txEmptyFixed();
    t_tx();
    t_rxBasic();
    t_clearRule();
    t_rxDisable();
    t_overrun();
    t_mpWait();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule